// File: doc/BRIEF.md
# Turn-Restricted Route Selector for a 2D Mesh Router

This block decides which output port the head flit of a packet leaves a mesh router by. It is given the router's own X/Y position, the packet's destination X/Y, the direction of the hop that brought the flit here, a routing-mode code and one congestion hint per neighbour port. It returns a one-hot port vector one cycle later. Four routing disciplines are available: strict X-then-Y ordering and three adaptive turn-restricted schemes (west moves first, north moves last, negative moves first). Only hops that shorten the distance to the destination are ever offered. When an adaptive scheme leaves two legal ports, the congestion hints break the choice.

The route is worked out once per packet, from the head flit. Body and tail flits of the same packet get the stored port again, whatever coordinates come with them. A small two-state controller tracks whether a packet is open. Its states are IDLE (no packet open) and PKT (a packet is open). Its transitions are OPEN (IDLE to PKT, on a head flit without tail), CLOSE (PKT to IDLE, on any flit carrying tail), HOLD (PKT to PKT, on a body flit), RESTART (PKT to PKT, on a new head flit without tail) and SINGLE (IDLE to IDLE, on a head flit that is also a tail). A body or tail flit that arrives in IDLE is an orphan: it causes no transition and gets no output.

Top module: `mesh_turn_route`

## Requirements
- R1: A flit accepted in cycle n gives o_valid high in cycle n+1. A flit is accepted if it is a valid head flit in any state, or a valid body or tail flit while a packet is open. In every other case o_valid is low in cycle n+1.
- R2: The o_port vector has at most one bit set. Bit 0 is local, bit 1 north (+Y), bit 2 south (-Y), bit 3 east (+X) and bit 4 west (-X).
- R3: A head flit whose destination equals the current node selects local (bit 0) in every mode.
- R4: Mode code 0 (XY): east or west is taken while the X coordinates differ. North or south is taken only once they are equal.
- R5: Mode code 1 (west first): if the destination lies to the west, only west is offered. Otherwise the block chooses adaptively among the productive east, north and south ports.
- R6: Mode code 2 (north last): north is offered only when the X coordinates are equal. East, west and south are offered whenever they are productive.
- R7: Mode code 3 (negative first): while west or south is productive, only those are offered. East and north are offered once no negative move is left.
- R8: Only productive ports are ever selected. Every route walked hop by hop reaches its destination in exactly |dx|+|dy| hops.
- R9: If two ports remain legal, the one with the smaller congestion hint wins, and equal hints favour the X port. i_cong holds 4-bit hints: bits [3:0] north, [7:4] south, [11:8] east, [15:12] west.
- R10: i_in_dir gives the direction of the arriving hop: 0 injected, 1 north, 2 south, 3 east, 4 west. A port that would make a turn the mode forbids is never selected. The forbidden turns are: XY, north or south followed by east or west; west first, north, south or east followed by west; north last, north followed by anything but north; negative first, east or north followed by west or south. If no legal productive port is left, o_port is all zero with o_valid high.
- R11: Body and tail flits of an open packet get the port computed for its head flit, whatever coordinates they carry.
- R12: A body or tail flit with no open packet is ignored. A flit with i_tail set closes the packet.
- R13: During reset o_valid and o_port are zero and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Flit strobe |
| i_head | input | 1 | Flit is the head of a packet |
| i_tail | input | 1 | Flit is the last of a packet |
| i_mode | input | 2 | Routing mode code |
| i_in_dir | input | 3 | Direction of the arriving hop |
| i_cur_x | input | X_W | Current node X |
| i_cur_y | input | Y_W | Current node Y |
| i_dst_x | input | X_W | Destination X |
| i_dst_y | input | Y_W | Destination Y |
| i_cong | input | 4*CONG_W | Congestion hints for north, south, east, west |
| o_valid | output | 1 | o_port is valid for the flit accepted last cycle |
| o_port | output | 5 | One-hot selected output port |

## Verification
The turn filter and the congestion comparison act on the same head flit in the same cycle. The bench provokes this by giving the lowest hint to a port that the arrival direction forbids, and by giving the two legal ports equal hints. A behavioural reference model judges each case, because it picks the cheapest allowed direction without knowing how the hardware is built. Packet control also coincides with route computation: a head flit that is also a tail, and a new head arriving while a packet is still open. Both are checked against the model in the cycle that follows.

// File: rtl/mesh_rc_pkg.sv
package mesh_rc_pkg;

    typedef enum logic [1:0] {
        MODE_XY         = 2'd0,
        MODE_WEST_FIRST = 2'd1,
        MODE_NORTH_LAST = 2'd2,
        MODE_NEG_FIRST  = 2'd3
    } rc_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PKT  = 1'b1
    } rc_state_e;

    localparam int NUM_PORTS = 5;

    localparam logic [2:0] DIR_LOCAL = 3'd0;
    localparam logic [2:0] DIR_NORTH = 3'd1;
    localparam logic [2:0] DIR_SOUTH = 3'd2;
    localparam logic [2:0] DIR_EAST  = 3'd3;
    localparam logic [2:0] DIR_WEST  = 3'd4;

    typedef logic [NUM_PORTS-1:0] port_vec_t;
    typedef logic [NUM_PORTS-1:1] dir_vec_t;

    // True when moving in nxt right after a hop in prev breaks the mode's turn rule
    function automatic logic turn_banned(rc_mode_e mode, logic [2:0] prev, logic [2:0] nxt);
        logic prev_y;
        logic nxt_x;
        logic res;
        prev_y = (prev == DIR_NORTH) || (prev == DIR_SOUTH);
        nxt_x  = (nxt == DIR_EAST) || (nxt == DIR_WEST);
        case (mode)
            MODE_XY:         res = prev_y && nxt_x;
            MODE_WEST_FIRST: res = (nxt == DIR_WEST) && (prev_y || (prev == DIR_EAST));
            MODE_NORTH_LAST: res = (prev == DIR_NORTH) && (nxt != DIR_NORTH) && (nxt != DIR_LOCAL);
            default:         res = ((prev == DIR_EAST) || (prev == DIR_NORTH)) &&
                                   ((nxt == DIR_WEST) || (nxt == DIR_SOUTH));
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rc_offsets.sv
module rc_offsets
    import mesh_rc_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output dir_vec_t       go,
    output logic           at_dest
);

    always_comb begin
        go            = '0;
        go[DIR_EAST]  = dst_x > cur_x;
        go[DIR_WEST]  = dst_x < cur_x;
        go[DIR_NORTH] = dst_y > cur_y;
        go[DIR_SOUTH] = dst_y < cur_y;
        at_dest       = (dst_x == cur_x) && (dst_y == cur_y);
    end

endmodule

// File: rtl/rc_legal_set.sv
module rc_legal_set
    import mesh_rc_pkg::*;
(
    input  rc_mode_e   mode,
    input  logic [2:0] in_dir,
    input  dir_vec_t   go,
    output dir_vec_t   legal
);

    dir_vec_t mode_ok;
    logic     x_left;
    logic     neg_left;

    // Phase rules of each discipline, before the turn check
    always_comb begin
        x_left   = go[DIR_EAST] | go[DIR_WEST];
        neg_left = go[DIR_WEST] | go[DIR_SOUTH];
        mode_ok  = go;
        unique case (mode)
            MODE_XY: begin
                mode_ok[DIR_NORTH] = go[DIR_NORTH] && !x_left;
                mode_ok[DIR_SOUTH] = go[DIR_SOUTH] && !x_left;
            end
            MODE_WEST_FIRST: begin
                mode_ok[DIR_NORTH] = go[DIR_NORTH] && !go[DIR_WEST];
                mode_ok[DIR_SOUTH] = go[DIR_SOUTH] && !go[DIR_WEST];
            end
            MODE_NORTH_LAST: begin
                mode_ok[DIR_NORTH] = go[DIR_NORTH] && !x_left;
            end
            MODE_NEG_FIRST: begin
                mode_ok[DIR_EAST]  = go[DIR_EAST] && !neg_left;
                mode_ok[DIR_NORTH] = go[DIR_NORTH] && !neg_left;
            end
        endcase
    end

    // Turn filter against the arriving hop, one slice per neighbour port
    for (genvar k = 1; k < NUM_PORTS; k++) begin : g_turn
        assign legal[k] = mode_ok[k] && !turn_banned(mode, in_dir, 3'(k));
    end

endmodule

// File: rtl/rc_pick.sv
module rc_pick
    import mesh_rc_pkg::*;
#(
    parameter int CONG_W = 4
) (
    input  dir_vec_t                          legal,
    input  logic                              at_dest,
    input  logic [(NUM_PORTS-1)*CONG_W-1:0]   cong,
    output port_vec_t                         pick
);

    logic [CONG_W-1:0] cong_a [1:NUM_PORTS-1];
    logic [CONG_W-1:0] x_c;
    logic [CONG_W-1:0] y_c;
    logic              x_ok;
    logic              y_ok;
    logic              take_x;

    for (genvar k = 1; k < NUM_PORTS; k++) begin : g_slice
        assign cong_a[k] = cong[(k-1)*CONG_W +: CONG_W];
    end

    always_comb begin
        x_ok   = legal[DIR_EAST] | legal[DIR_WEST];
        y_ok   = legal[DIR_NORTH] | legal[DIR_SOUTH];
        x_c    = legal[DIR_EAST] ? cong_a[DIR_EAST] : cong_a[DIR_WEST];
        y_c    = legal[DIR_NORTH] ? cong_a[DIR_NORTH] : cong_a[DIR_SOUTH];
        take_x = x_ok && (!y_ok || (x_c <= y_c));
        pick   = '0;
        if (at_dest) begin
            pick[DIR_LOCAL] = 1'b1;
        end else if (take_x) begin
            if (legal[DIR_EAST]) pick[DIR_EAST] = 1'b1;
            else                 pick[DIR_WEST] = 1'b1;
        end else if (y_ok) begin
            if (legal[DIR_NORTH]) pick[DIR_NORTH] = 1'b1;
            else                  pick[DIR_SOUTH] = 1'b1;
        end
    end

endmodule

// File: rtl/mesh_turn_route.sv
module mesh_turn_route
    import mesh_rc_pkg::*;
#(
    parameter int X_W    = 4,
    parameter int Y_W    = 4,
    parameter int CONG_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_valid,
    input  logic                  i_head,
    input  logic                  i_tail,
    input  logic [1:0]            i_mode,
    input  logic [2:0]            i_in_dir,
    input  logic [X_W-1:0]        i_cur_x,
    input  logic [Y_W-1:0]        i_cur_y,
    input  logic [X_W-1:0]        i_dst_x,
    input  logic [Y_W-1:0]        i_dst_y,
    input  logic [4*CONG_W-1:0]   i_cong,
    output logic                  o_valid,
    output logic [4:0]            o_port
);

    rc_state_e state, state_nxt;
    rc_mode_e  mode;
    dir_vec_t  go;
    dir_vec_t  legal;
    port_vec_t pick;
    logic      at_dest;
    logic      accept_head;
    logic      accept_rest;

    assign mode        = rc_mode_e'(i_mode);
    assign accept_head = i_valid && i_head;
    assign accept_rest = i_valid && !i_head && (state == ST_PKT);

    rc_offsets #(.X_W(X_W), .Y_W(Y_W)) u_off (
        .cur_x(i_cur_x), .cur_y(i_cur_y), .dst_x(i_dst_x), .dst_y(i_dst_y),
        .go(go), .at_dest(at_dest)
    );

    rc_legal_set u_legal (
        .mode(mode), .in_dir(i_in_dir), .go(go), .legal(legal)
    );

    rc_pick #(.CONG_W(CONG_W)) u_pick (
        .legal(legal), .at_dest(at_dest), .cong(i_cong), .pick(pick)
    );

    // Packet tracking: OPEN, CLOSE, HOLD, RESTART, SINGLE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept_head && !i_tail) state_nxt = ST_PKT;
            ST_PKT:  if (i_valid && i_tail)      state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_port  <= '0;
        end else begin
            o_valid <= accept_head || accept_rest;
            if (accept_head) o_port <= pick;
        end
    end

    // Support for the turn check: does the candidate port make a banned turn
    logic bad_turn;
    always_comb begin
        bad_turn = 1'b0;
        for (int k = 1; k < NUM_PORTS; k++) begin
            if (pick[k] && turn_banned(mode, i_in_dir, 3'(k))) bad_turn = 1'b1;
        end
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_head || accept_rest) |=> o_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_head || accept_rest) |=> !o_valid);
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(o_port));
    a_r3_eject_local: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_head && (i_cur_x == i_dst_x) && (i_cur_y == i_dst_y)) |=> (o_port == 5'b00001));
    a_r4_x_before_y: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_head && (mode == MODE_XY) && (i_cur_x != i_dst_x)) |=> (o_port[2:1] == 2'b00));
    a_r8_productive: assert property (@(posedge clk) disable iff (!rst_n)
        accept_head |-> ((!pick[DIR_EAST]  || (i_dst_x > i_cur_x)) &&
                         (!pick[DIR_WEST]  || (i_dst_x < i_cur_x)) &&
                         (!pick[DIR_NORTH] || (i_dst_y > i_cur_y)) &&
                         (!pick[DIR_SOUTH] || (i_dst_y < i_cur_y))));
    a_r10_no_banned_turn: assert property (@(posedge clk) disable iff (!rst_n)
        accept_head |-> !bad_turn);
    a_r11_reuse_port: assert property (@(posedge clk) disable iff (!rst_n)
        accept_rest |=> $stable(o_port));
    a_r12_orphan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_head && (state == ST_IDLE)) |=> !o_valid);

endmodule

// File: tb/sim_mesh_turn_route.sv
`timescale 1ns/1ps
module sim_mesh_turn_route;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0, hd = 1'b0, tl = 1'b0;
    logic [1:0]  md = '0;
    logic [2:0]  idir = '0;
    logic [3:0]  cx = '0, cy = '0, tx = '0, ty = '0;
    logic [15:0] cong = '0;
    logic        o_valid;
    logic [4:0]  o_port;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    logic  exp_v = 1'b0;
    logic [4:0] exp_p = '0;
    bit    open_pkt = 0;
    string pend = "R13";

    always #2.5 clk = ~clk;

    mesh_turn_route u0 (
        .clk(clk), .rst_n(rst_n), .i_valid(v), .i_head(hd), .i_tail(tl),
        .i_mode(md), .i_in_dir(idir), .i_cur_x(cx), .i_cur_y(cy),
        .i_dst_x(tx), .i_dst_y(ty), .i_cong(cong),
        .o_valid(o_valid), .o_port(o_port)
    );

    function automatic logic [15:0] mkc(int n, int s, int e, int w);
        return {4'(w), 4'(e), 4'(s), 4'(n)};
    endfunction

    function automatic bit ref_banned(int m, int prev, int d);
        bit py = (prev == 1) || (prev == 2);
        case (m)
            0: return py && (d == 3 || d == 4);
            1: return (d == 4) && (py || prev == 3);
            2: return (prev == 1) && (d != 1);
            default: return (prev == 3 || prev == 1) && (d == 4 || d == 2);
        endcase
    endfunction

    // Cheapest allowed productive direction; X directions are visited first so ties go to X
    function automatic logic [4:0] ref_route(int m, int prev, int x, int y, int qx, int qy, logic [15:0] cg);
        int ddx = qx - x;
        int ddy = qy - y;
        int ord [4] = '{3, 4, 1, 2};
        int best = -1;
        int bestc = 1000;
        if (ddx == 0 && ddy == 0) return 5'b00001;
        foreach (ord[i]) begin
            int d = ord[i];
            bit prod = (d == 3 && ddx > 0) || (d == 4 && ddx < 0) ||
                       (d == 1 && ddy > 0) || (d == 2 && ddy < 0);
            bit ok = prod;
            int c = int'(cg[(d-1)*4 +: 4]);
            if (m == 0 && (d == 1 || d == 2) && ddx != 0) ok = 0;
            if (m == 1 && ddx < 0 && d != 4) ok = 0;
            if (m == 2 && d == 1 && ddx != 0) ok = 0;
            if (m == 3 && (ddx < 0 || ddy < 0) && !(d == 4 || d == 2)) ok = 0;
            if (ok && !ref_banned(m, prev, d) && c < bestc) begin
                best = d;
                bestc = c;
            end
        end
        return (best < 0) ? 5'b00000 : 5'(1 << best);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Compare last cycle's result, then drive this cycle's flit and advance the model
    task automatic step(input logic vv, hh, tt, input int m, pd, x, y, qx, qy,
                        input logic [15:0] cg, input string tag);
        @(negedge clk);
        n_vec++;
        if (o_valid !== exp_v || o_port !== exp_p) begin
            n_bad++;
            $display("FAIL %s: valid/port actual %b/%b expected %b/%b", pend, o_valid, o_port, exp_v, exp_p);
        end
        v = vv; hd = hh; tl = tt; md = 2'(m); idir = 3'(pd);
        cx = 4'(x); cy = 4'(y); tx = 4'(qx); ty = 4'(qy); cong = cg;
        if (!rst_n) begin
            exp_v = 0; exp_p = '0; open_pkt = 0;
        end else if (vv && hh) begin
            exp_v = 1; exp_p = ref_route(m, pd, x, y, qx, qy, cg); open_pkt = !tt;
        end else if (vv && open_pkt) begin
            exp_v = 1; if (tt) open_pkt = 0;
        end else begin
            exp_v = 0;
        end
        pend = tag;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic walk(input int m, int sx, int sy, int qx, int qy);
        int x = sx, y = sy, prev = 0, hops = 0;
        bit broken = 0;
        bit turn_err = 0;
        while (!(x == qx && y == qy) && hops < 40 && !broken) begin
            step(1, 1, 1, m, prev, x, y, qx, qy, 16'($urandom), "R8");
            idle("R10");
            case (o_port)
                5'b00010: begin if (ref_banned(m, prev, 1)) turn_err = 1; y++; prev = 1; end
                5'b00100: begin if (ref_banned(m, prev, 2)) turn_err = 1; y--; prev = 2; end
                5'b01000: begin if (ref_banned(m, prev, 3)) turn_err = 1; x++; prev = 3; end
                5'b10000: begin if (ref_banned(m, prev, 4)) turn_err = 1; x--; prev = 4; end
                default:  broken = 1;
            endcase
            hops++;
        end
        n_vec++;
        if (turn_err) begin
            n_bad++;
            $display("FAIL R10: mode %0d walk made a banned turn actual 1 expected 0", m);
        end
        n_vec++;
        if (broken || hops != ((qx > sx ? qx - sx : sx - qx) + (qy > sy ? qy - sy : sy - qy))) begin
            n_bad++;
            $display("FAIL R8: mode %0d hops actual %0d expected %0d", m, hops,
                     (qx > sx ? qx - sx : sx - qx) + (qy > sy ? qy - sy : sy - qy));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: run actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) idle("R13");
        rst_n = 1'b1;
        idle("R13");
        // R3 ejection in each mode
        for (int m = 0; m < 4; m++) step(1, 1, 1, m, 3, 6, 6, 6, 6, mkc(0,0,0,0), "R3");
        // R4 XY ordering
        step(1, 1, 1, 0, 0, 2, 2, 5, 7, mkc(0,0,9,0), "R4");
        step(1, 1, 1, 0, 3, 5, 2, 5, 7, mkc(0,0,0,0), "R4");
        // R5 west first
        step(1, 1, 1, 1, 0, 8, 2, 3, 9, mkc(0,0,0,15), "R5");
        step(1, 1, 1, 1, 0, 2, 2, 9, 9, mkc(1,0,7,0), "R5");
        // R6 north last
        step(1, 1, 1, 2, 0, 2, 2, 9, 9, mkc(0,0,15,0), "R6");
        step(1, 1, 1, 2, 0, 2, 9, 9, 2, mkc(0,3,8,0), "R6");
        // R7 negative first
        step(1, 1, 1, 3, 0, 2, 9, 9, 2, mkc(0,15,0,0), "R7");
        step(1, 1, 1, 3, 0, 9, 9, 2, 2, mkc(0,5,0,4), "R7");
        // R9 ties and cheaper port
        step(1, 1, 1, 3, 0, 2, 2, 9, 9, mkc(6,0,6,0), "R9");
        step(1, 1, 1, 1, 0, 2, 9, 9, 2, mkc(0,6,6,0), "R9");
        step(1, 1, 1, 3, 0, 2, 2, 9, 9, mkc(5,0,6,0), "R9");
        // R10 arrival direction forbids the cheap port, or every port
        step(1, 1, 1, 2, 1, 2, 2, 9, 9, mkc(0,0,15,0), "R10");
        step(1, 1, 1, 0, 1, 2, 2, 9, 2, mkc(0,0,0,0), "R10");
        step(1, 1, 1, 3, 3, 9, 9, 2, 2, mkc(0,0,0,0), "R10");
        step(1, 1, 1, 1, 1, 9, 2, 2, 9, mkc(0,0,0,0), "R10");
        idle("R1");
        // R11 body flits reuse the head result; R12 tail closes, orphans ignored
        step(1, 1, 0, 0, 0, 2, 2, 9, 2, mkc(0,0,0,0), "R1");
        step(1, 0, 0, 0, 0, 9, 9, 2, 2, mkc(0,0,0,0), "R11");
        step(1, 0, 1, 0, 0, 5, 5, 5, 9, mkc(0,0,0,0), "R11");
        step(1, 0, 0, 0, 0, 2, 2, 2, 9, mkc(0,0,0,0), "R12");
        step(1, 0, 1, 0, 0, 2, 2, 2, 9, mkc(0,0,0,0), "R12");
        // RESTART: a new head while a packet is open
        step(1, 1, 0, 3, 0, 9, 9, 2, 2, mkc(0,0,0,0), "R1");
        step(1, 1, 0, 2, 0, 2, 2, 2, 9, mkc(0,0,0,0), "R11");
        step(1, 0, 0, 2, 0, 7, 7, 0, 0, mkc(0,0,0,0), "R11");
        step(1, 0, 1, 2, 0, 7, 7, 0, 0, mkc(0,0,0,0), "R12");
        idle("R12");
        idle("R1");
        // Random walks across the mesh in every mode
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 30; i++) begin
                walk(m, int'($urandom_range(15)), int'($urandom_range(15)),
                        int'($urandom_range(15)), int'($urandom_range(15)));
            end
        end
        idle("R2");
        idle("R1");
        finish_run();
    end

endmodule